// File: doc/BRIEF.md
# Debug monitor entry controller

This block sits beside the chip's reset logic and decides, at the moment the reset pin is released, whether the chip starts in a serial debug monitor instead of running user code. The decision comes from three flags that are already synchronous to the bus clock. Two of them report a raised test voltage, one on the interrupt pin and one on the reset pin. The third reports an erased reset vector. The block also drives the watchdog disable for as long as the chosen entry path calls for it. When the reset vector is blank it asks once for one more reset cycle after power-up.

Once in the monitor, the block listens on a single receive wire for the host's eight security bytes. It passes each byte out with a strobe and its position, and it does not judge them. It then holds its transmit wire low for ten bit times as a break. When the break ends it raises a one-clock ready-for-command pulse. One bit lasts a fixed 256 bus clocks. With a 9.8304 MHz crystal and the bus running at a quarter of that rate, this gives 9600 baud.

Top module: `mon_entry_ctrl`

## Requirements
- R1: Entry is decided only on the first clock in which `pin_rst` is seen high after being low. While `pin_rst` stays high, later changes on `irq_hv`, `rst_hv` or `vec_blank` leave `mon_mode` unchanged.
- R2: At that edge, `irq_hv` high selects voltage entry, whatever `vec_blank` is. Otherwise `vec_blank` high selects blank-vector entry. Otherwise the chip starts normally, with `mon_mode` 0, `wdog_dis` 0 and `tx` held high (idle).
- R3: The first blank-vector entry after `rst_n` is released raises `extra_rst_req` for exactly one clock. Later entries raise it again only after a new `rst_n`, and voltage entry never raises it.
- R4: In monitor mode the block receives exactly eight bytes on `rx`, LSB first. Each byte is a low start bit, eight data bits and a high stop bit, with 256 clocks per bit and sampling at mid-bit. Each byte appears on `sec_byte` with a one-clock `sec_valid`, and `sec_idx` counts 0 to 7 in arrival order.
- R5: After the eighth byte, `tx` goes low for exactly 2560 consecutive clocks (ten bit times). At all other times `tx` is high.
- R6: `cmd_ready` is high for one clock: the first clock in which `tx` is high again after the break. It is never high at any other time.
- R7: After blank-vector entry, `wdog_dis` stays 1 whatever `irq_hv` and `rst_hv` do.
- R8: After voltage entry, `wdog_dis` equals the OR of `irq_hv` and `rst_hv` from the previous clock, so it drops once both flags are low.
- R9: A low `pin_rst` returns the block to waiting within one clock. `mon_mode` and `wdog_dis` clear, any break in progress stops with `tx` high, and the next entry numbers its bytes from index 0 again.
- R10: Bytes on `rx` are ignored outside the security phase (in normal start, and after the break): `sec_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| pin_rst | input | 1 | Reset pin level, synchronous, high = released |
| irq_hv | input | 1 | Test voltage present on the interrupt pin |
| rst_hv | input | 1 | Test voltage present on the reset pin |
| vec_blank | input | 1 | Reset vector reads as erased |
| rx | input | 1 | Serial receive line from the host, idle high |
| mon_mode | output | 1 | Monitor mode latched |
| wdog_dis | output | 1 | Watchdog disable |
| extra_rst_req | output | 1 | One-clock request for one more reset cycle |
| tx | output | 1 | Serial transmit line, idle high |
| sec_byte | output | 8 | Last received security byte |
| sec_valid | output | 1 | One-clock strobe for `sec_byte` |
| sec_idx | output | 3 | Position 0..7 of the byte on `sec_byte` |
| cmd_ready | output | 1 | One-clock pulse when the break ends |

## Verification
The assertions assume that `pin_rst` and the three entry flags are already synchronous to `clk`. They also assume the host never drives `rx` except with whole, well-formed bytes. The bench changes the flags only on falling clock edges. It raises `pin_rst` only after at least one low cycle, and it sends each frame with a full stop bit before the next start bit. So the mid-bit sampler and the edge detector never see an input that changes within a clock.

// File: rtl/mon_pkg.sv
// Shared types for the debug monitor entry controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package mon_pkg;

    // Which path, if any, put the chip into monitor mode
    typedef enum logic [1:0] {
        ENT_OFF   = 2'd0,
        ENT_HV    = 2'd1,
        ENT_BLANK = 2'd2
    } entry_t;

    // Top-level sequencing phases
    typedef enum logic [2:0] {
        SQ_WAIT = 3'd0,
        SQ_USER = 3'd1,
        SQ_SEC  = 3'd2,
        SQ_BRK  = 3'd3,
        SQ_CMD  = 3'd4
    } seq_t;

endpackage

// File: rtl/mon_entry_latch.sv
// Entry decision: finds the rising edge of the reset pin, classifies the
// entry path, holds it until the pin drops, and drives the watchdog
// disable and the one-time extra reset request.
// Assumes: pin_rst, irq_hv, rst_hv, vec_blank are synchronous to clk.
module mon_entry_latch
    import mon_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_rst,
    input  logic   irq_hv,
    input  logic   rst_hv,
    input  logic   vec_blank,
    output entry_t entry,
    output logic   entry_seen,
    output logic   wdog_dis,
    output logic   extra_req
);

    logic   pin_q;
    logic   rise;
    logic   extra_done;
    entry_t entry_nx;

    assign rise = pin_rst & ~pin_q;

    // Next entry class: cleared by a low pin, chosen at the rising edge
    always_comb begin
        entry_nx = entry;
        if (!pin_rst) begin
            entry_nx = ENT_OFF;
        end else if (rise) begin
            if (irq_hv) begin
                entry_nx = ENT_HV;
            end else if (vec_blank) begin
                entry_nx = ENT_BLANK;
            end else begin
                entry_nx = ENT_OFF;
            end
        end
    end

    // Pin history and latched entry class
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q      <= 1'b1;
            entry      <= ENT_OFF;
            entry_seen <= 1'b0;
        end else begin
            pin_q      <= pin_rst;
            entry      <= entry_nx;
            entry_seen <= rise;
        end
    end

    // Watchdog disable follows the class it will hold next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdog_dis <= 1'b0;
        end else begin
            wdog_dis <= (entry_nx == ENT_BLANK) |
                        ((entry_nx == ENT_HV) & (irq_hv | rst_hv));
        end
    end

    // One extra reset request, only for the first blank-vector entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            extra_req  <= 1'b0;
            extra_done <= 1'b0;
        end else begin
            extra_req <= rise & (entry_nx == ENT_BLANK) & ~extra_done;
            if (rise && entry_nx == ENT_BLANK) begin
                extra_done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mon_uart_rx.sv
// Single-wire byte receiver: start bit, DATA_BITS data bits LSB first,
// one stop bit, BIT_CLKS clocks per bit, sampled at mid-bit. A frame
// whose stop bit is low is dropped. Clearing en returns it to idle.
// Assumes: rx is asynchronous (it is synchronised here), BIT_CLKS >= 4.
module mon_uart_rx #(
    parameter int BIT_CLKS  = 256,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 rx,
    output logic [DATA_BITS-1:0] data,
    output logic                 valid
);

    localparam int CNT_W = $clog2(BIT_CLKS);
    localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BIT_CLKS - 1);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(BIT_CLKS / 2 - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;

    rx_st_t               st;
    logic [1:0]           sync;
    logic                 rxs;
    logic [CNT_W-1:0]     cnt;
    logic [BIT_W-1:0]     bitn;
    logic [DATA_BITS-1:0] shreg;

    assign rxs = sync[1];

    // Two-flop synchroniser for the receive wire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync <= 2'b11;
        end else begin
            sync <= {sync[0], rx};
        end
    end

    // Frame state machine with mid-bit sampling
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (st)
                RX_IDLE: begin
                    cnt <= '0;
                    if (!rxs) begin
                        st <= RX_START;
                    end
                end
                RX_START: begin
                    if (cnt == HALF_CNT) begin
                        cnt  <= '0;
                        bitn <= '0;
                        st   <= rxs ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == LAST_CNT) begin
                        cnt   <= '0;
                        shreg <= {rxs, shreg[DATA_BITS-1:1]};
                        if (bitn == LAST_BIT) begin
                            st <= RX_STOP;
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == LAST_CNT) begin
                        cnt <= '0;
                        st  <= RX_IDLE;
                        if (rxs) begin
                            data  <= shreg;
                            valid <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mon_break_tx.sv
// Break generator: on start, holds the line low for BRK_BITS bit times of
// BIT_CLKS clocks each, then pulses done in the first idle-high clock.
// clr aborts at once and leaves the line high.
// Assumes: start is not raised while a break is running.
module mon_break_tx #(
    parameter int BIT_CLKS = 256,
    parameter int BRK_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic line,
    output logic done
);

    localparam int BRK_CLKS = BIT_CLKS * BRK_BITS;
    localparam int CNT_W    = $clog2(BRK_CLKS);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BRK_CLKS - 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;

    assign line = ~busy;

    // Low-time counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (cnt == LAST_CNT) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end
    end

endmodule

// File: rtl/mon_entry_ctrl.sv
// Debug monitor entry controller. Latches the entry path when the reset
// pin is released. In monitor mode it collects SEC_BYTES security bytes,
// reports each with its index, sends a break and then signals readiness.
// Assumes: all flag inputs synchronous to clk; rx may be asynchronous.
module mon_entry_ctrl
    import mon_pkg::*;
#(
    parameter int BIT_CLKS  = 256,
    parameter int SEC_BYTES = 8,
    parameter int BRK_BITS  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_rst,
    input  logic       irq_hv,
    input  logic       rst_hv,
    input  logic       vec_blank,
    input  logic       rx,
    output logic       mon_mode,
    output logic       wdog_dis,
    output logic       extra_rst_req,
    output logic       tx,
    output logic [7:0] sec_byte,
    output logic       sec_valid,
    output logic [2:0] sec_idx,
    output logic       cmd_ready
);

    localparam int IDX_W = $clog2(SEC_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEC_BYTES - 1);

    entry_t           entry_mode;
    logic             entry_seen;
    seq_t             seq;
    logic             rx_en;
    logic [7:0]       rx_data;
    logic             rx_valid;
    logic             brk_start;
    logic             brk_done;
    logic [IDX_W-1:0] byte_cnt;

    mon_entry_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_rst    (pin_rst),
        .irq_hv     (irq_hv),
        .rst_hv     (rst_hv),
        .vec_blank  (vec_blank),
        .entry      (entry_mode),
        .entry_seen (entry_seen),
        .wdog_dis   (wdog_dis),
        .extra_req  (extra_rst_req)
    );

    mon_uart_rx #(.BIT_CLKS(BIT_CLKS), .DATA_BITS(8)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rx_en),
        .rx    (rx),
        .data  (rx_data),
        .valid (rx_valid)
    );

    mon_break_tx #(.BIT_CLKS(BIT_CLKS), .BRK_BITS(BRK_BITS)) u_brk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~pin_rst),
        .start (brk_start),
        .line  (tx),
        .done  (brk_done)
    );

    assign mon_mode  = (entry_mode != ENT_OFF);
    assign rx_en     = (seq == SQ_SEC) & pin_rst;
    assign sec_valid = rx_valid & (seq == SQ_SEC);
    assign sec_byte  = rx_data;
    assign sec_idx   = 3'(byte_cnt);
    assign brk_start = sec_valid & (byte_cnt == LAST_IDX);
    assign cmd_ready = brk_done;

    // Phase sequencing from reset wait through handshake to command idle
    always_ff @(posedge clk) begin
        if (!rst_n || !pin_rst) begin
            seq <= SQ_WAIT;
        end else begin
            case (seq)
                SQ_WAIT: if (entry_seen) seq <= mon_mode ? SQ_SEC : SQ_USER;
                SQ_SEC:  if (brk_start)  seq <= SQ_BRK;
                SQ_BRK:  if (brk_done)   seq <= SQ_CMD;
                default: seq <= seq;
            endcase
        end
    end

    // Security byte index, restarted on every reset-pin assertion
    always_ff @(posedge clk) begin
        if (!rst_n || !pin_rst) begin
            byte_cnt <= '0;
        end else if (sec_valid) begin
            byte_cnt <= byte_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mon_entry_ctrl_chk.sv
// Assertion checker for mon_entry_ctrl, attached by bind below.
// Assumes: same clock and reset as the checked instance.
module mon_entry_ctrl_chk
    import mon_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   pin_rst,
    input logic   irq_hv,
    input logic   rst_hv,
    input logic   mon_mode,
    input logic   wdog_dis,
    input logic   extra_rst_req,
    input logic   tx,
    input logic   sec_valid,
    input logic   cmd_ready,
    input entry_t entry
);

    // R1: mode holds while the pin has been high for three cycles
    p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_rst && $past(pin_rst) && $past(pin_rst, 2)) |-> $stable(mon_mode));

    // R2: outside the monitor the watchdog runs and tx idles
    p_normal_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_mode |-> (!wdog_dis && tx));

    // R3: extra reset request is a single clock
    p_extra_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        extra_rst_req |=> !extra_rst_req);

    // R4: security bytes are only reported in monitor mode
    p_sec_in_mon_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |-> mon_mode);

    // R6: ready pulse marks the return of tx to high
    p_ready_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (tx && !$past(tx)));

    // R6: ready is one clock long
    p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |=> !cmd_ready);

    // R7: blank-vector entry keeps the watchdog off
    p_wdog_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (entry == ENT_BLANK) |-> wdog_dis);

    // R8: voltage entry tracks the high-voltage flags one clock late
    p_wdog_hv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (entry == ENT_HV) |-> (wdog_dis == $past(irq_hv || rst_hv)));

    // R9: a low reset pin clears the mode and releases tx
    p_pin_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_rst |=> (!mon_mode && !wdog_dis && tx));

endmodule

bind mon_entry_ctrl mon_entry_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_rst       (pin_rst),
    .irq_hv        (irq_hv),
    .rst_hv        (rst_hv),
    .mon_mode      (mon_mode),
    .wdog_dis      (wdog_dis),
    .extra_rst_req (extra_rst_req),
    .tx            (tx),
    .sec_valid     (sec_valid),
    .cmd_ready     (cmd_ready),
    .entry         (entry_mode)
);

// File: tb/sim_mon_entry_ctrl.sv
// Scoreboard bench for mon_entry_ctrl.
module sim_mon_entry_ctrl;

    localparam int BIT_CLKS = 256;
    localparam int BRK_CLKS = 10 * BIT_CLKS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_rst = 1'b0;
    logic       irq_hv = 1'b0;
    logic       rst_hv = 1'b0;
    logic       vec_blank = 1'b0;
    logic       rx = 1'b1;
    logic       mon_mode, wdog_dis, extra_rst_req, tx, sec_valid, cmd_ready;
    logic [7:0] sec_byte;
    logic [2:0] sec_idx;

    mon_entry_ctrl #(.BIT_CLKS(BIT_CLKS)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_rst(pin_rst), .irq_hv(irq_hv),
        .rst_hv(rst_hv), .vec_blank(vec_blank), .rx(rx),
        .mon_mode(mon_mode), .wdog_dis(wdog_dis), .extra_rst_req(extra_rst_req),
        .tx(tx), .sec_byte(sec_byte), .sec_valid(sec_valid),
        .sec_idx(sec_idx), .cmd_ready(cmd_ready)
    );

    always #10 clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;
    logic [10:0] exp_q[$];
    int          exp_idx = 0;
    int          brk_seen = 0;
    int          run = 0;
    int          extra_cnt = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected bytes, measures breaks, counts extra requests
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (sec_valid) begin
                if (exp_q.size() == 0) begin
                    check("R10 byte reported outside security phase", 1, 0);
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    check("R4 index and byte", int'({sec_idx, sec_byte}), int'(e));
                end
            end
            if (extra_rst_req) extra_cnt++;
            if (!tx) begin
                run++;
            end else if (run > 0) begin
                check("R5 break length", run, BRK_CLKS);
                check("R6 ready at break end", int'(cmd_ready), 1);
                brk_seen++;
                run = 0;
            end else if (cmd_ready) begin
                check("R6 ready without break", 1, 0);
            end
        end
    end

    task automatic enter(input logic irq, input logic blank);
        @(negedge clk);
        pin_rst = 1'b0;
        repeat (4) @(negedge clk);
        irq_hv = irq;
        vec_blank = blank;
        @(negedge clk);
        pin_rst = 1'b1;
        exp_idx = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit want);
        if (want) begin
            exp_q.push_back({3'(exp_idx), b});
            exp_idx++;
        end
        rx = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rx = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_break(input int n);
        for (int i = 0; i < 4000 && brk_seen < n; i++) @(negedge clk);
        check("R5 break observed", brk_seen, n);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 reset mon_mode", int'(mon_mode), 0);
        check("R2 reset wdog_dis", int'(wdog_dis), 0);
        check("R5 reset tx idle", int'(tx), 1);
        check("R6 reset cmd_ready", int'(cmd_ready), 0);

        // Normal start: no entry condition
        enter(1'b0, 1'b0);
        check("R2 normal mon_mode", int'(mon_mode), 0);
        check("R2 normal wdog_dis", int'(wdog_dis), 0);
        send_byte(8'h5A, 1'b0);
        check("R10 normal tx idle", int'(tx), 1);

        // Voltage entry, blank flag also set: voltage wins
        enter(1'b1, 1'b1);
        check("R2 hv entry mon_mode", int'(mon_mode), 1);
        check("R3 no extra request on hv entry", extra_cnt, 0);
        check("R8 wdog with irq_hv", int'(wdog_dis), 1);
        @(negedge clk);
        irq_hv = 1'b0; vec_blank = 1'b0; rst_hv = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 mode held after pin changes", int'(mon_mode), 1);
        check("R8 wdog with rst_hv only", int'(wdog_dis), 1);
        rst_hv = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 wdog released", int'(wdog_dis), 0);
        rst_hv = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 wdog restored", int'(wdog_dis), 1);
        rst_hv = 1'b0;
        for (int k = 0; k < 8; k++) send_byte(8'(k * 37 + 5), 1'b1);
        wait_break(1);
        send_byte(8'hC3, 1'b0);
        check("R4 all bytes seen", exp_q.size(), 0);

        // Blank-vector entry, aborted by the reset pin after three bytes
        enter(1'b0, 1'b1);
        check("R3 extra request once", extra_cnt, 1);
        vec_blank = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 wdog with flags low", int'(wdog_dis), 1);
        irq_hv = 1'b1;
        repeat (3) @(negedge clk);
        irq_hv = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 wdog after irq toggle", int'(wdog_dis), 1);
        for (int k = 0; k < 3; k++) send_byte(8'(8'hF0 - k * 11), 1'b1);
        pin_rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 mode cleared", int'(mon_mode), 0);
        check("R9 wdog cleared", int'(wdog_dis), 0);
        check("R9 partial bytes seen", exp_q.size(), 0);

        // Blank-vector entry again: no second request, index restarts
        enter(1'b0, 1'b1);
        check("R3 no second extra request", extra_cnt, 1);
        for (int k = 0; k < 8; k++) send_byte(8'(k * 91 + 17), 1'b1);
        wait_break(2);
        check("R9 index restarted, all bytes seen", exp_q.size(), 0);
        check("R6 ready low after break", int'(cmd_ready), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog ends a hung run as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule